// File: doc/BRIEF.md
# Odd-Word Packet Pad and Strip Across a 2:1 Width Boundary

This block holds the two width adapters that sit on either side of a double-width buffer. The ingress adapter accepts 72-bit packet words (an 8-bit control field above 64 data bits, plus an end-of-packet flag) and packs them two by two into 144-bit words. When a packet holds an odd number of narrow words, its final word would have no partner. The adapter therefore completes the wide word with a filler word, so no half-filled wide word is ever left waiting at a packet boundary.

The egress adapter splits each 144-bit word back into two 72-bit words and drops the filler again. The packet that leaves therefore matches the packet that entered, word for word, with its end flag in the same place. The two adapters share only clock and reset, and whatever storage lies between them is outside this block. Every edge uses a valid/ready handshake and tolerates back-pressure. A filler word has control code 8'hFE and an all-zero data field. This control code is reserved: ingress traffic must never carry it.

Top module: `nps_pad_strip`

## Requirements
- R1: After reset, neither output valid is asserted, and both input ready signals are high.
- R2: The first narrow word of each pair is placed in bits [143:72] of the wide word and the second in bits [71:0].
- R3: The final word of a packet with an odd word count goes to bits [143:72]. Bits [71:0] then hold the filler word (control 8'hFE in bits [71:64], data bits all zero), and the wide end flag is set.
- R4: The last pair of a packet with an even word count carries no filler and has the wide end flag set. No earlier wide word of that packet has the flag.
- R5: Egress sends bits [143:72] of a wide word first and bits [71:0] second.
- R6: When a wide word has its end flag set and a lower half with control 8'hFE, egress drops that lower half and puts the narrow end flag on the upper half.
- R7: The narrow end flag at egress marks only the last real word of each packet, and the number of words per packet at egress equals the number at ingress.
- R8: While an output is valid and not accepted, its word and end flag hold steady. Under any pattern of back-pressure, no word is lost or duplicated.
- R9: A one-word packet produces exactly one wide word: that word followed by the filler, with the end flag set.
- R10: A lower half with control 8'hFE in a wide word whose end flag is clear is passed out unchanged and is not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ig_valid | input | 1 | Narrow ingress word valid |
| ig_ready | output | 1 | Narrow ingress word accepted |
| ig_word | input | 72 | Narrow ingress word: control [71:64], data [63:0] |
| ig_last | input | 1 | Ingress word is the last of its packet |
| ig_wide_valid | output | 1 | Packed wide word valid |
| ig_wide_ready | input | 1 | Downstream takes the packed wide word |
| ig_wide_word | output | 144 | Packed wide word |
| ig_wide_last | output | 1 | Packed wide word ends a packet |
| eg_wide_valid | input | 1 | Wide word to unpack is valid |
| eg_wide_ready | output | 1 | Unpacker takes the wide word |
| eg_wide_word | input | 144 | Wide word to unpack |
| eg_wide_last | input | 1 | Wide word ends a packet |
| eg_valid | output | 1 | Narrow egress word valid |
| eg_ready | input | 1 | Downstream takes the narrow egress word |
| eg_word | output | 72 | Narrow egress word |
| eg_last | output | 1 | Narrow egress word ends a packet |

## Verification
Suppose the ingress holding register lost its occupancy bit. A word would then be dropped or paired with the wrong partner, and the next wide word out would show the mismatch at once. Suppose the egress half selector stuck or flipped. Within one wide word, the narrow output would show a repeated half, a swapped order, or a leaked filler word with control 8'hFE. A wrong end-flag placement shows on the very word it affects. A held output that changes under back-pressure shows as a duplicated or missing word against the scoreboard within a few cycles.

// File: rtl/nps_pkg.sv
package nps_pkg;
  localparam int unsigned NARROW_W_DEF = 72;
  localparam int unsigned CTL_W_DEF    = 8;
  localparam logic [7:0]  PAD_CTL_DEF  = 8'hFE;
endpackage

// File: rtl/nps_packer.sv
module nps_packer #(
  parameter int unsigned NW = nps_pkg::NARROW_W_DEF,
  parameter int unsigned CW = nps_pkg::CTL_W_DEF,
  parameter logic [CW-1:0] PAD_CTL = nps_pkg::PAD_CTL_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [NW-1:0]   in_word,
  input  logic            in_last,
  output logic            o_valid,
  input  logic            o_ready,
  output logic [2*NW-1:0] o_word,
  output logic            o_last
);
  localparam int unsigned WW = 2 * NW;
  localparam int unsigned DW = NW - CW;

  function automatic logic [NW-1:0] make_pad();
    return {PAD_CTL, {DW{1'b0}}};
  endfunction

  function automatic logic [WW-1:0] join_pair(input logic [NW-1:0] hi, input logic [NW-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic is_pad(input logic [NW-1:0] w);
    return w[NW-1 -: CW] == PAD_CTL;
  endfunction

  logic          hold_v;
  logic [NW-1:0] hold_w;
  logic          out_v;
  logic [WW-1:0] out_w;
  logic          out_l;

  // named internal events
  logic out_free, in_fire, emit_pair, emit_padded, park;
  logic [WW-1:0] next_w;

  always_comb begin
    out_free    = !out_v || o_ready;
    in_ready    = (hold_v || in_last) ? out_free : 1'b1;
    in_fire     = in_valid && in_ready;
    emit_pair   = in_fire && hold_v;
    emit_padded = in_fire && !hold_v && in_last;
    park        = in_fire && !hold_v && !in_last;
    next_w      = emit_pair ? join_pair(hold_w, in_word) : join_pair(in_word, make_pad());
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_w <= '0;
      out_v  <= 1'b0;
      out_w  <= '0;
      out_l  <= 1'b0;
    end else begin
      if (emit_pair || emit_padded) begin
        out_v <= 1'b1;
        out_w <= next_w;
        out_l <= in_last;
      end else if (o_ready) begin
        out_v <= 1'b0;
      end
      if (park) begin
        hold_v <= 1'b1;
        hold_w <= in_word;
      end else if (emit_pair) begin
        hold_v <= 1'b0;
      end
    end
  end

  assign o_valid = out_v;
  assign o_word  = out_w;
  assign o_last  = out_l;

  AST_PAD_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && is_pad(o_word[NW-1:0]) |-> o_last); // R3
  AST_WIDE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_word) && $stable(o_last)); // R8
  AST_PAIR_CLOSES_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && in_valid && in_ready && in_last |=> o_valid && o_last && !hold_v); // R4
endmodule

// File: rtl/nps_unpacker.sv
module nps_unpacker #(
  parameter int unsigned NW = nps_pkg::NARROW_W_DEF,
  parameter int unsigned CW = nps_pkg::CTL_W_DEF,
  parameter logic [CW-1:0] PAD_CTL = nps_pkg::PAD_CTL_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            w_valid,
  output logic            w_ready,
  input  logic [2*NW-1:0] w_word,
  input  logic            w_last,
  output logic            o_valid,
  input  logic            o_ready,
  output logic [NW-1:0]   o_word,
  output logic            o_last
);
  localparam int unsigned WW = 2 * NW;

  function automatic logic is_pad(input logic [NW-1:0] w);
    return w[NW-1 -: CW] == PAD_CTL;
  endfunction

  function automatic logic [NW-1:0] upper_half(input logic [WW-1:0] w);
    return w[WW-1:NW];
  endfunction

  function automatic logic [NW-1:0] lower_half(input logic [WW-1:0] w);
    return w[NW-1:0];
  endfunction

  logic          r_v;
  logic          r_l;
  logic [WW-1:0] r_w;
  logic          half_sel; // 0: upper half pending, 1: lower half pending

  // named internal events
  logic drop_lo, out_fire, done, w_fire;

  always_comb begin
    drop_lo  = r_l && is_pad(lower_half(r_w));
    o_valid  = r_v;
    o_word   = half_sel ? lower_half(r_w) : upper_half(r_w);
    o_last   = half_sel ? r_l : drop_lo;
    out_fire = o_valid && o_ready;
    done     = out_fire && (half_sel || drop_lo);
    w_ready  = !r_v || done;
    w_fire   = w_valid && w_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_v      <= 1'b0;
      r_l      <= 1'b0;
      r_w      <= '0;
      half_sel <= 1'b0;
    end else begin
      if (w_fire) begin
        r_v      <= 1'b1;
        r_w      <= w_word;
        r_l      <= w_last;
        half_sel <= 1'b0;
      end else if (done) begin
        r_v      <= 1'b0;
        half_sel <= 1'b0;
      end else if (out_fire) begin
        half_sel <= 1'b1;
      end
    end
  end

  AST_NARROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_word) && $stable(o_last)); // R8
  AST_NO_PAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_last |-> !is_pad(o_word)); // R7
  AST_LOWER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_ready && !half_sel && !drop_lo |=> o_valid && half_sel); // R5
endmodule

// File: rtl/nps_pad_strip.sv
module nps_pad_strip #(
  parameter int unsigned NW = nps_pkg::NARROW_W_DEF,
  parameter int unsigned CW = nps_pkg::CTL_W_DEF,
  parameter logic [CW-1:0] PAD_CTL = nps_pkg::PAD_CTL_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ig_valid,
  output logic            ig_ready,
  input  logic [NW-1:0]   ig_word,
  input  logic            ig_last,
  output logic            ig_wide_valid,
  input  logic            ig_wide_ready,
  output logic [2*NW-1:0] ig_wide_word,
  output logic            ig_wide_last,
  input  logic            eg_wide_valid,
  output logic            eg_wide_ready,
  input  logic [2*NW-1:0] eg_wide_word,
  input  logic            eg_wide_last,
  output logic            eg_valid,
  input  logic            eg_ready,
  output logic [NW-1:0]   eg_word,
  output logic            eg_last
);
  nps_packer #(.NW(NW), .CW(CW), .PAD_CTL(PAD_CTL)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ig_valid), .in_ready(ig_ready), .in_word(ig_word), .in_last(ig_last),
    .o_valid(ig_wide_valid), .o_ready(ig_wide_ready), .o_word(ig_wide_word), .o_last(ig_wide_last)
  );

  nps_unpacker #(.NW(NW), .CW(CW), .PAD_CTL(PAD_CTL)) u_unpack (
    .clk(clk), .rst_n(rst_n),
    .w_valid(eg_wide_valid), .w_ready(eg_wide_ready), .w_word(eg_wide_word), .w_last(eg_wide_last),
    .o_valid(eg_valid), .o_ready(eg_ready), .o_word(eg_word), .o_last(eg_last)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !ig_wide_valid && !eg_valid); // R1
endmodule

// File: tb/test_nps_pad_strip.sv
module test_nps_pad_strip;
  localparam logic [7:0] PAD = 8'hFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ig_valid = 1'b0, ig_last = 1'b0;
  logic [71:0] ig_word = '0;
  logic ig_ready, ig_wide_valid, ig_wide_last, ig_wide_ready;
  logic [143:0] ig_wide_word;
  logic eg_wide_valid, eg_wide_ready, eg_wide_last;
  logic [143:0] eg_wide_word;
  logic eg_valid, eg_last;
  logic eg_ready = 1'b1;
  logic [71:0] eg_word;

  logic direct = 1'b0, bp = 1'b0, finished = 1'b0;
  logic tb_wv = 1'b0, tb_wl = 1'b0;
  logic [143:0] tb_ww = '0;

  assign eg_wide_valid = direct ? tb_wv : ig_wide_valid;
  assign eg_wide_word  = direct ? tb_ww : ig_wide_word;
  assign eg_wide_last  = direct ? tb_wl : ig_wide_last;
  assign ig_wide_ready = direct ? 1'b0  : eg_wide_ready;

  nps_pad_strip i_nps_pad_strip (
    .clk(clk), .rst_n(rst_n),
    .ig_valid(ig_valid), .ig_ready(ig_ready), .ig_word(ig_word), .ig_last(ig_last),
    .ig_wide_valid(ig_wide_valid), .ig_wide_ready(ig_wide_ready),
    .ig_wide_word(ig_wide_word), .ig_wide_last(ig_wide_last),
    .eg_wide_valid(eg_wide_valid), .eg_wide_ready(eg_wide_ready),
    .eg_wide_word(eg_wide_word), .eg_wide_last(eg_wide_last),
    .eg_valid(eg_valid), .eg_ready(eg_ready), .eg_word(eg_word), .eg_last(eg_last)
  );

  int checks = 0, errors = 0;
  logic [144:0] exp_w[$];
  logic [72:0]  exp_n[$];

  task automatic check(input bit ok, input string tag, input logic [144:0] act, input logic [144:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) eg_ready = bp ? ($urandom % 4 != 0) : 1'b1;

  // monitors: sample away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (!direct && ig_wide_valid && ig_wide_ready) begin
        if (exp_w.size() == 0) check(0, "R2 R3 R4 unexpected wide word", {ig_wide_last, ig_wide_word}, '0);
        else begin
          logic [144:0] e;
          e = exp_w.pop_front();
          check({ig_wide_last, ig_wide_word} === e, "R2 R3 R4 wide word", {ig_wide_last, ig_wide_word}, e);
        end
      end
      if (eg_valid && eg_ready) begin
        if (exp_n.size() == 0) check(0, "R5 R6 R7 unexpected narrow word", {72'h0, eg_last, eg_word}, '0);
        else begin
          logic [72:0] e;
          e = exp_n.pop_front();
          check({eg_last, eg_word} === e, "R5 R6 R7 narrow word", {72'h0, eg_last, eg_word}, {72'h0, e});
        end
      end
    end
  end

  task automatic send_pkt(input int len);
    logic [71:0] upper = '0;
    for (int i = 0; i < len; i++) begin
      logic [71:0] w;
      logic l;
      w = {8'($urandom) & 8'h7F, $urandom, $urandom};
      l = (i == len - 1);
      exp_n.push_back({l, w});
      if (i % 2 == 0) begin
        upper = w;
        if (l) exp_w.push_back({1'b1, w, PAD, 64'h0});
      end else begin
        exp_w.push_back({l, upper, w});
      end
      @(negedge clk);
      ig_valid = 1'b1; ig_word = w; ig_last = l;
      #1;
      while (!ig_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      if (bp && ($urandom % 3 == 0)) begin @(negedge clk); ig_valid = 1'b0; end
    end
    @(negedge clk);
    ig_valid = 1'b0;
  endtask

  task automatic send_wide(input logic [143:0] w, input logic l);
    @(negedge clk);
    tb_wv = 1'b1; tb_ww = w; tb_wl = l;
    #1;
    while (!eg_wide_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    tb_wv = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((exp_w.size() != 0 || exp_n.size() != 0) && n < 2000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    check(exp_w.size() == 0, tag, 145'(exp_w.size()), '0);
    check(exp_n.size() == 0, tag, 145'(exp_n.size()), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check(!ig_wide_valid, "R1 wide output idle", 145'(ig_wide_valid), '0);
    check(!eg_valid, "R1 narrow output idle", 145'(eg_valid), '0);
    check(ig_ready, "R1 ingress ready", 145'(ig_ready), 145'(1));
    check(eg_wide_ready, "R1 egress ready", 145'(eg_wide_ready), 145'(1));

    send_pkt(1); // R9 single word
    send_pkt(2); // R4 even
    send_pkt(3); // R3 odd
    send_pkt(4);
    send_pkt(5);
    drain("R7 R9 all words delivered");

    bp = 1'b1; // R8 back-pressure
    for (int p = 0; p < 25; p++) send_pkt(1 + int'($urandom % 9));
    drain("R8 no loss under back-pressure");
    bp = 1'b0;

    direct = 1'b1;
    // R10 filler code without end flag passes through
    exp_n.push_back({1'b0, 8'h11, 64'h1111}); exp_n.push_back({1'b0, PAD, 64'h0});
    send_wide({8'h11, 64'h1111, PAD, 64'h0}, 1'b0);
    // R6 filler with end flag dropped, end moves to upper
    exp_n.push_back({1'b1, 8'h22, 64'h2222});
    send_wide({8'h22, 64'h2222, PAD, 64'h0}, 1'b1);
    // R5 order upper then lower
    exp_n.push_back({1'b0, 8'h33, 64'h3333}); exp_n.push_back({1'b1, 8'h44, 64'h4444});
    send_wide({8'h33, 64'h3333, 8'h44, 64'h4444}, 1'b1);
    drain("R5 R6 R10 direct egress");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule